// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers thirteen event conditions of a serial port into one interrupt request. Each event has a status bit that latches when the event condition rises and holds until software writes a one to it. A mask chooses which latched bits may drive the interrupt. The mask has two write ports, one that only sets bits and one that only clears them, so software never needs a read-modify-write sequence. The current mask value can be read back.

The block works out the queue-related conditions itself from the receive and transmit queue fill levels: empty, full, nearly full, and two programmable fill thresholds. It also holds a receive idle timer. This timer raises a timeout event when the receive queue holds data and no character has arrived for a programmed number of clock cycles. Line errors, overruns and modem-line changes arrive as plain condition inputs.

Software reaches the block through a simple port. A write is a single-cycle strobe with a 3-bit address and a data word. A read is a combinational look-up by address.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: Status bit positions are: 0 rx threshold, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 rx overrun, 6 framing error, 7 parity error, 8 rx idle timeout, 9 modem change, 10 tx threshold, 11 tx nearly full, 12 tx overrun. A bit is set one cycle after its condition goes from low to high, whatever the mask holds. A condition that stays high sets its bit only once.
- R2: A write to address 0 sets every mask bit whose data bit is one. A write to address 1 clears every mask bit whose data bit is one. Data bits that are zero leave the mask unchanged. Address 2 reads the mask. Addresses 0, 1 and 7 read as zero.
- R3: The status word is read at address 3. A bit stays set until a write to address 3 has a one in that bit position. Zero data bits clear nothing, and writing 0x1FFF clears every bit.
- R4: When an event rises in the same cycle as a clear write to its bit, the bit ends up set.
- R5: `irq` is high exactly when some status bit is set and its mask bit is also set.
- R6: Level conditions: rx empty when `rx_level`==0, rx full when `rx_level`>=DEPTH, tx empty when `tx_level`==0, tx full when `tx_level`>=DEPTH, tx nearly full when `tx_level`>=DEPTH-1.
- R7: The rx threshold condition is `rx_level` >= the value at address 4 (reset DEPTH/2). The tx threshold condition is `tx_level` >= the value at address 5 (reset DEPTH/2). A threshold of zero turns that condition off.
- R8: The idle timer counts clock edges while the receive queue is non-empty and `rx_push` is low. It re-arms on `rx_push`, on an empty queue, or on a restart. If the last re-arm is sampled at edge E0, status bit 8 first reads one after edge E0+L+1, where L is the limit at address 6. It then stays one and raises one event until the timer is re-armed again.
- R9: The idle limit at address 6 resets to 10, and a limit of 0 disables the timeout event.
- R10: A write to address 7 with data bit 0 set restarts the idle count from that edge.
- R11: While reset is held, status, mask and `irq` are zero. On the first edge after reset, the rx empty and tx empty bits latch, because the previous condition levels reset to zero.
- R12: `line_ev` bit 0 drives rx overrun, bit 1 framing error, bit 2 parity error, bit 3 modem change and bit 4 tx overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 13 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 13 | Read data for `rd_addr` |
| rx_level | input | $clog2(DEPTH+1) | Receive queue fill level |
| tx_level | input | $clog2(DEPTH+1) | Transmit queue fill level |
| rx_push | input | 1 | A character entered the receive queue this cycle |
| line_ev | input | 5 | Line, overrun and modem-change conditions |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DEPTH=8, so the levels are 4 bits wide. This makes the full (8) and nearly-full (7) levels, and a threshold above DEPTH, reachable with direct values. Limits of 5, 3 and small random values keep the idle timeout within a few cycles. The exact timeout edge, restart and zero-limit cases are checked against hand-counted edges. The random phase mixes level changes, pushes, line pulses and writes to every address, and compares the status word, the mask and `irq` on each cycle against a reference model in the bench.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;
  localparam int NUM_EV   = 13;
  localparam int NUM_LINE = 5;

  // status bit positions (software decodes these)
  localparam int EV_RX_TRIG  = 0;
  localparam int EV_RX_EMPTY = 1;
  localparam int EV_RX_FULL  = 2;
  localparam int EV_TX_EMPTY = 3;
  localparam int EV_TX_FULL  = 4;
  localparam int EV_RX_OVR   = 5;
  localparam int EV_FRAME    = 6;
  localparam int EV_PARITY   = 7;
  localparam int EV_RX_STALE = 8;
  localparam int EV_MODEM    = 9;
  localparam int EV_TX_TRIG  = 10;
  localparam int EV_TX_NFULL = 11;
  localparam int EV_TX_OVR   = 12;

  // line condition input positions
  localparam int LN_RX_OVR = 0;
  localparam int LN_FRAME  = 1;
  localparam int LN_PARITY = 2;
  localparam int LN_MODEM  = 3;
  localparam int LN_TX_OVR = 4;

  localparam int CTRL_RESTART_BIT = 0;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  typedef enum logic [2:0] {
    RA_EN_SET = 3'd0,
    RA_EN_CLR = 3'd1,
    RA_MASK   = 3'd2,
    RA_STATUS = 3'd3,
    RA_RX_WM  = 3'd4,
    RA_TX_WM  = 3'd5,
    RA_IDLE   = 3'd6,
    RA_CTRL   = 3'd7
  } reg_addr_e;

  // threshold reached; a zero threshold never fires
  function automatic logic wm_reached(int lvl, int wm);
    return (wm != 0) && (lvl >= wm);
  endfunction

  function automatic ev_vec_t rising(ev_vec_t now_v, ev_vec_t before_v);
    return now_v & ~before_v;
  endfunction

  // new events win over a clear in the same cycle
  function automatic ev_vec_t sticky_next(ev_vec_t cur, ev_vec_t w1c, ev_vec_t rise);
    return (cur & ~w1c) | rise;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_sticky_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int TMO_W     = 8,
  parameter int DW        = 13,
  parameter int RX_WM_RST = 32,
  parameter int TX_WM_RST = 32,
  parameter int IDLE_RST  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  ev_vec_t          status_q,
  output ev_vec_t          mask_q,
  output logic [LVL_W-1:0] rx_wm_q,
  output logic [LVL_W-1:0] tx_wm_q,
  output logic [TMO_W-1:0] idle_lim_q,
  output ev_vec_t          status_w1c,
  output logic             restart
);
  ev_vec_t   wr_ev;
  reg_addr_e wa;
  reg_addr_e ra;

  assign wr_ev = wr_data[NUM_EV-1:0];
  assign wa    = reg_addr_e'(wr_addr);
  assign ra    = reg_addr_e'(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      rx_wm_q    <= LVL_W'(RX_WM_RST);
      tx_wm_q    <= LVL_W'(TX_WM_RST);
      idle_lim_q <= TMO_W'(IDLE_RST);
    end else if (wr_en) begin
      case (wa)
        RA_EN_SET: mask_q     <= mask_q | wr_ev;
        RA_EN_CLR: mask_q     <= mask_q & ~wr_ev;
        RA_RX_WM:  rx_wm_q    <= wr_data[LVL_W-1:0];
        RA_TX_WM:  tx_wm_q    <= wr_data[LVL_W-1:0];
        RA_IDLE:   idle_lim_q <= wr_data[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  assign status_w1c = (wr_en && wa == RA_STATUS) ? wr_ev : '0;
  assign restart    = wr_en && (wa == RA_CTRL) && wr_data[CTRL_RESTART_BIT];

  always_comb begin
    rd_data = '0;
    case (ra)
      RA_MASK:   rd_data[NUM_EV-1:0] = mask_q;
      RA_STATUS: rd_data[NUM_EV-1:0] = status_q;
      RA_RX_WM:  rd_data[LVL_W-1:0]  = rx_wm_q;
      RA_TX_WM:  rd_data[LVL_W-1:0]  = tx_wm_q;
      RA_IDLE:   rd_data[TMO_W-1:0]  = idle_lim_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_ev_detect.sv
module irq_ev_detect
  import irq_sticky_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [LVL_W-1:0]    tx_level,
  input  logic [LVL_W-1:0]    rx_wm,
  input  logic [LVL_W-1:0]    tx_wm,
  input  logic [NUM_LINE-1:0] line_ev,
  input  logic                stale,
  output ev_vec_t             ev_rise
);
  ev_vec_t cond;
  ev_vec_t prev_q;

  always_comb begin
    cond = '0;
    cond[EV_RX_TRIG]  = wm_reached(int'(rx_level), int'(rx_wm));
    cond[EV_RX_EMPTY] = (rx_level == '0);
    cond[EV_RX_FULL]  = (int'(rx_level) >= DEPTH);
    cond[EV_TX_EMPTY] = (tx_level == '0);
    cond[EV_TX_FULL]  = (int'(tx_level) >= DEPTH);
    cond[EV_TX_NFULL] = (int'(tx_level) >= DEPTH - 1);
    cond[EV_TX_TRIG]  = wm_reached(int'(tx_level), int'(tx_wm));
    cond[EV_RX_OVR]   = line_ev[LN_RX_OVR];
    cond[EV_FRAME]    = line_ev[LN_FRAME];
    cond[EV_PARITY]   = line_ev[LN_PARITY];
    cond[EV_MODEM]    = line_ev[LN_MODEM];
    cond[EV_TX_OVR]   = line_ev[LN_TX_OVR];
    cond[EV_RX_STALE] = stale;
  end

  for (genvar b = 0; b < NUM_EV; b++) begin : g_prev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[b] <= 1'b0;
      else        prev_q[b] <= cond[b];
    end
  end

  assign ev_rise = rising(cond, prev_q);
endmodule

// File: rtl/irq_stale_timer.sv
module irq_stale_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_nonempty,
  input  logic             rx_push,
  input  logic             restart,
  input  logic [TMO_W-1:0] idle_lim,
  output logic             stale
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   cnt_inc;
  logic             rearm;
  logic             lim_hit;

  assign rearm   = !q_nonempty || (idle_lim == '0) || rx_push || restart;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign lim_hit = cnt_inc >= {1'b0, idle_lim};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stale <= 1'b0;
    end else if (rearm) begin
      cnt_q <= '0;
      stale <= 1'b0;
    end else if (!stale) begin
      if (lim_hit) begin
        cnt_q <= '0;
        stale <= 1'b1;
      end else begin
        cnt_q <= cnt_inc[TMO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
  import irq_sticky_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev_rise,
  input  ev_vec_t status_w1c,
  output ev_vec_t status_q
);
  ev_vec_t status_d;

  always_comb status_d = sticky_next(status_q, status_w1c, ev_rise);

  for (genvar b = 0; b < NUM_EV; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= status_d[b];
    end
  end
endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_sticky_pkg::*;
#(
  parameter int  DEPTH     = 64,
  parameter int  TMO_W     = 8,
  parameter int  RX_WM_RST = DEPTH / 2,
  parameter int  TX_WM_RST = DEPTH / 2,
  parameter int  IDLE_RST  = 10,
  localparam int LVL_W     = $clog2(DEPTH + 1),
  localparam int DW        = NUM_EV
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [2:0]          rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [LVL_W-1:0]    tx_level,
  input  logic                rx_push,
  input  logic [NUM_LINE-1:0] line_ev,
  output logic                irq
);
  ev_vec_t          mask_q;
  ev_vec_t          status_q;
  ev_vec_t          status_w1c;
  ev_vec_t          ev_rise;
  logic [LVL_W-1:0] rx_wm_q;
  logic [LVL_W-1:0] tx_wm_q;
  logic [TMO_W-1:0] idle_lim_q;
  logic             restart;
  logic             stale;

  irq_cfg_regs #(
    .LVL_W(LVL_W), .TMO_W(TMO_W), .DW(DW),
    .RX_WM_RST(RX_WM_RST), .TX_WM_RST(TX_WM_RST), .IDLE_RST(IDLE_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .status_q(status_q), .mask_q(mask_q),
    .rx_wm_q(rx_wm_q), .tx_wm_q(tx_wm_q), .idle_lim_q(idle_lim_q),
    .status_w1c(status_w1c), .restart(restart)
  );

  irq_stale_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .q_nonempty(rx_level != '0), .rx_push(rx_push), .restart(restart),
    .idle_lim(idle_lim_q), .stale(stale)
  );

  irq_ev_detect #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_wm(rx_wm_q), .tx_wm(tx_wm_q),
    .line_ev(line_ev), .stale(stale), .ev_rise(ev_rise)
  );

  irq_status_bits u_status (
    .clk(clk), .rst_n(rst_n),
    .ev_rise(ev_rise), .status_w1c(status_w1c), .status_q(status_q)
  );

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_sticky_ctrl_chk.sv
module irq_sticky_ctrl_chk
  import irq_sticky_pkg::*;
#(
  parameter int DW    = 13,
  parameter int LVL_W = 7,
  parameter int TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [LVL_W-1:0] rx_level,
  input logic             irq,
  input ev_vec_t          mask_q,
  input ev_vec_t          status_q,
  input ev_vec_t          ev_rise,
  input ev_vec_t          status_w1c,
  input logic             stale,
  input logic [TMO_W-1:0] idle_lim_q
);
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ev_rise)) == '0)); // R1

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_EN_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_EN_CLR) |=> ((mask_q & $past(wr_data)) == '0)); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~status_w1c)) == $past(status_q & ~status_w1c))); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_STATUS && wr_data == '1) |=> (status_q == $past(ev_rise))); // R3

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rise != '0) |=> ((status_q & $past(ev_rise)) == $past(ev_rise))); // R4

  AST_IRQ_OFF_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_EN_CLR && wr_data == '1) |=> !irq); // R5

  AST_STALE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stale |-> ($past(rx_level) != '0)); // R8

  AST_STALE_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idle_lim_q) == '0) |-> !stale); // R9
endmodule

bind irq_sticky_ctrl irq_sticky_ctrl_chk #(
  .DW(DW), .LVL_W(LVL_W), .TMO_W(TMO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_level(rx_level), .irq(irq),
  .mask_q(mask_q), .status_q(status_q), .ev_rise(ev_rise),
  .status_w1c(status_w1c), .stale(stale), .idle_lim_q(idle_lim_q)
);

// File: tb/irq_sticky_ctrl_bench.sv
module irq_sticky_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LVL_W      = 4;
  localparam int DW         = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [2:0]       rd_addr = 3'd3;
  logic [DW-1:0]    rd_data;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] tx_level = '0;
  logic             rx_push = 1'b0;
  logic [4:0]       line_ev = '0;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;

  irq_sticky_ctrl #(.DEPTH(DEPTH), .TMO_W(8)) u_irq_sticky_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_level(rx_level), .tx_level(tx_level), .rx_push(rx_push),
    .line_ev(line_ev), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model state
  logic [12:0] mask_m = '0, status_m = '0, prev_m = '0;
  logic [3:0]  rxwm_m = 4'd4, txwm_m = 4'd4;
  logic [7:0]  lim_m = 8'd10, cnt_m = '0;
  logic        stale_m = 1'b0;

  function automatic logic [12:0] cond_of(logic [3:0] rl, logic [3:0] tl, logic [4:0] le,
                                          logic st, logic [3:0] rw, logic [3:0] tw);
    logic [12:0] r;
    r      = '0;
    r[0]   = (rw != 0) && (rl >= rw);
    r[1]   = (rl == 0);
    r[2]   = (rl == DEPTH);
    r[3]   = (tl == 0);
    r[4]   = (tl == DEPTH);
    r[5]   = le[0];
    r[6]   = le[1];
    r[7]   = le[2];
    r[8]   = st;
    r[9]   = le[3];
    r[10]  = (tw != 0) && (tl >= tw);
    r[11]  = (tl >= DEPTH - 1);
    r[12]  = le[4];
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd2: return 32'(mask_m);
      3'd3: return 32'(status_m);
      3'd4: return 32'(rxwm_m);
      3'd5: return 32'(txwm_m);
      3'd6: return 32'(lim_m);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [12:0] c;
    logic [12:0] d;
    logic        rs;
    if (!rst_n) begin
      mask_m = '0; status_m = '0; prev_m = '0;
      rxwm_m = 4'd4; txwm_m = 4'd4; lim_m = 8'd10; cnt_m = '0; stale_m = 1'b0;
    end else begin
      c = cond_of(rx_level, tx_level, line_ev, stale_m, rxwm_m, txwm_m);
      d = wr_data;
      for (int b = 0; b < 13; b++) begin
        if (c[b] && !prev_m[b])                      status_m[b] = 1'b1;
        else if (wr_en && wr_addr == 3'd3 && d[b])   status_m[b] = 1'b0;
      end
      prev_m = c;
      rs = wr_en && wr_addr == 3'd7 && d[0];
      if (rx_level == 0 || lim_m == 0 || rx_push || rs) begin
        cnt_m = '0; stale_m = 1'b0;
      end else if (!stale_m) begin
        cnt_m = cnt_m + 8'd1;
        if (cnt_m >= lim_m) begin stale_m = 1'b1; cnt_m = '0; end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: mask_m = mask_m | d;
          3'd1: mask_m = mask_m & ~d;
          3'd4: rxwm_m = d[3:0];
          3'd5: txwm_m = d[3:0];
          3'd6: lim_m  = d[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd_lit(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, 32'(rd_data), exp);
  endtask

  task automatic rd_model(input string req, input logic [2:0] a);
    rd_addr = a; #1;
    chk(req, 32'(rd_data), model_read(a));
  endtask

  task automatic bit_is(input string req, input int b, input logic exp);
    rd_addr = 3'd3; #1;
    chk(req, 32'(rd_data[b]), 32'(exp));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [12:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    rd_lit("R11 status in reset", 3'd3, 32'h0);
    rd_lit("R11 mask in reset", 3'd2, 32'h0);
    chk("R11 irq in reset", 32'(irq), 32'd0);
    rd_lit("R9 idle limit reset value", 3'd6, 32'd10);
    rd_lit("R7 rx threshold reset value", 3'd4, 32'd4);
    rst_n = 1'b1;
    tick();
    rd_lit("R11 empty bits after first edge", 3'd3, 32'h000A);

    // R2 split enable ports
    wr(3'd0, 13'h0005); rd_lit("R2 set", 3'd2, 32'h0005);
    wr(3'd0, 13'h0100); rd_lit("R2 set keeps others", 3'd2, 32'h0105);
    wr(3'd1, 13'h0001); rd_lit("R2 clear", 3'd2, 32'h0104);
    rd_lit("R2 set port reads zero", 3'd0, 32'h0);
    rd_lit("R2 clear port reads zero", 3'd1, 32'h0);
    rd_lit("R2 ctrl reads zero", 3'd7, 32'h0);
    chk("R5 no overlap no irq", 32'(irq), 32'd0);
    wr(3'd0, 13'h0008);
    chk("R5 enabled set bit raises irq", 32'(irq), 32'd1);
    wr(3'd1, 13'h1FFF);
    chk("R5 masked bit drops irq", 32'(irq), 32'd0);
    rd_lit("R5 status kept while masked", 3'd3, 32'h000A);

    // R3 write-one-to-clear
    wr(3'd3, 13'h0000); rd_lit("R3 zeros clear nothing", 3'd3, 32'h000A);
    wr(3'd3, 13'h1FFF); rd_lit("R3 all ones clear", 3'd3, 32'h0);

    // R12 / R1 line conditions
    line_ev = 5'b00010; tick(); line_ev = '0;
    rd_lit("R12 framing to bit 6", 3'd3, 32'h0040);
    line_ev = 5'b10000; tick(); tick(); tick();
    rd_lit("R12 tx overrun to bit 12", 3'd3, 32'h1040);
    wr(3'd3, 13'h1000);
    rd_lit("R1 held condition latches once", 3'd3, 32'h0040);
    line_ev = '0; tick();
    line_ev = 5'b01000; tick(); line_ev = '0;
    rd_lit("R12 modem to bit 9", 3'd3, 32'h0240);
    line_ev = 5'b00101; tick(); line_ev = '0;
    rd_lit("R12 overrun and parity to bits 5 7", 3'd3, 32'h02E0);
    chk("R1 latched with mask clear, irq low", 32'(irq), 32'd0);

    // R4 event beats clear
    line_ev = 5'b00010;
    wr(3'd3, 13'h1FFF);
    line_ev = '0;
    rd_lit("R4 event wins over clear", 3'd3, 32'h0040);

    // R6 / R7 levels
    wr(3'd3, 13'h1FFF);
    tx_level = 4'd7; tick();
    rd_lit("R6 tx nearly full and R7 tx threshold", 3'd3, 32'h0C00);
    tx_level = 4'd8; tick();
    rd_lit("R6 tx full", 3'd3, 32'h0C10);
    rx_level = 4'd8; tick();
    rd_lit("R6 rx full and R7 rx threshold", 3'd3, 32'h0C15);
    rx_level = 4'd0; tick();
    rd_lit("R6 rx empty", 3'd3, 32'h0C17);
    tx_level = 4'd0; tick();
    rd_lit("R6 tx empty", 3'd3, 32'h0C1F);
    wr(3'd3, 13'h1FFF);
    wr(3'd4, 13'd0);
    rx_level = 4'd8; tick();
    bit_is("R7 zero threshold off", 0, 1'b0);
    bit_is("R6 rx full with threshold off", 2, 1'b1);
    rx_level = 4'd0; tick();
    wr(3'd4, 13'd6);
    rx_level = 4'd5; tick();
    bit_is("R7 below threshold", 0, 1'b0);
    rx_level = 4'd6; tick();
    bit_is("R7 at threshold", 0, 1'b1);
    rx_level = 4'd0; tick();

    // R8 idle timeout edge
    wr(3'd6, 13'd5);
    wr(3'd3, 13'h1FFF);
    rx_level = 4'd2; rx_push = 1'b1; tick(); rx_push = 1'b0;
    for (int j = 1; j <= 8; j++) begin
      tick();
      bit_is("R8 timeout edge", 8, j >= 6);
    end
    wr(3'd3, 13'h0100);
    tick(); tick(); tick();
    bit_is("R8 one event per idle period", 8, 1'b0);

    // R10 restart
    rx_push = 1'b1; tick(); rx_push = 1'b0;
    tick(); tick();
    wr(3'd7, 13'h0001);
    for (int j = 1; j <= 7; j++) begin
      tick();
      bit_is("R10 restart moves timeout", 8, j >= 6);
    end

    // R9 zero limit
    wr(3'd6, 13'd0);
    wr(3'd3, 13'h1FFF);
    rx_push = 1'b1; tick(); rx_push = 1'b0;
    repeat (20) tick();
    bit_is("R9 zero limit disables timeout", 8, 1'b0);
    rx_level = 4'd0;
    wr(3'd6, 13'd3);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_addr = 3'($urandom_range(0, 7));
      wr_data = 13'($urandom);
      if (wr_addr == 3'd6) wr_data = 13'($urandom_range(0, 12));
      if (wr_addr == 3'd3 && $urandom_range(0, 1) == 0) wr_data = 13'h1FFF;
      if ($urandom_range(0, 3) == 0) rx_level = 4'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 3) == 0) tx_level = 4'($urandom_range(0, DEPTH));
      rx_push = ($urandom_range(0, 7) == 0);
      for (int b = 0; b < 5; b++) line_ev[b] = ($urandom_range(0, 5) == 0);
      tick();
      rd_model("R3 status vs model", 3'd3);
      rd_model("R2 mask vs model", 3'd2);
      chk("R5 irq vs model", 32'(irq), 32'(|(status_m & mask_m)));
    end
    wr_en = 1'b0;
    tick();
    rd_model("R8 final status vs model", 3'd3);

    summary();
    $finish;
  end
endmodule